// File: doc/BRIEF.md
# Dual-Pattern Serial Sequence Detector

This block watches a one-bit serial stream, sampling it on every rising clock edge, and raises a flag whenever the four most recent samples form either of two 4-bit patterns: a run of four zeros, or a zero, two ones and a zero in that order. Detection overlaps, so a longer zero run, or a stream such as 0110110, keeps producing hits without first returning to an idle state.

The detector is a Moore machine with eight states. The flag is decoded from the current state alone, so it changes only at a clock edge. A parameter chooses how the state is stored. One setting uses eight flip-flops with exactly one bit set. The other uses a dense 3-bit binary code. The current state is brought out on an observation port so that a surrounding test structure or debug path can follow the machine. Reset is active low and synchronous.

Top module: `seq_dual_detect`

## Requirements
- R1: After a clock edge at which the last four samples of `w_in` taken since reset were all 0, `z_out` is 1.
- R2: Detection overlaps. While `z_out` is 1 after a four-zero run, each further 0 keeps `z_out` at 1. After 0110, the samples 1,1,0 produce a second hit.
- R3: After a clock edge at which the last four samples taken since reset were 0,1,1,0 (oldest first), `z_out` is 1.
- R4: With `ENC_SEL` = 0 (one-hot), `st_obs` has exactly one bit set. State A is bit 0, B is bit 1, and so on up to H at bit 7.
- R5: With `ENC_SEL` = 1 (binary), `st_obs[2:0]` holds the state index (A=0 through H=7) and every higher bit of `st_obs` is 0.
- R6: Reset is active low and synchronous. A low `rst_n` at a rising edge puts the machine in state A with `z_out` = 0. Lowering `rst_n` between edges changes neither `z_out` nor `st_obs` before the next edge.
- R7: `z_out` depends on the current state only. A change on `w_in` between edges leaves `z_out` unchanged until the next edge.
- R8: The states mean the following. A: no useful prefix. B, C, D: one, two or three trailing zeros. E: four or more zeros. F: the last samples are 0,1. G: the last samples are 0,1,1. H: 0,1,1,0 has just been seen. The transitions are:

| From | w=0 | w=1 |
|------|-----|-----|
| A | B | A |
| B | C | F |
| C | D | F |
| D | E | F |
| E | E | F |
| F | B | G |
| G | H | A |
| H | C | F |

- R9: In every other case `z_out` is 0. This includes the first three edges after reset, whatever the samples were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock that samples `w_in` |
| rst_n | input | 1 | Active-low synchronous reset to state A |
| w_in | input | 1 | Serial input bit |
| z_out | output | 1 | Match flag: 1 when the last four samples form a wanted pattern |
| st_obs | output | OBS_W (8) | Current state code, zero-extended to `OBS_W` bits |

## Verification
Directed runs of five or more zeros separate overlapping detection from a machine that returns to idle after a hit. The repeated stream 0110110 checks the H-to-F path that lets a second 0110 reuse the tail of the first. Near misses such as 0111, 010, 000-then-1 and a pattern split by a reset show which states each prefix leaves, and a mid-cycle toggle of the input or of the reset shows that the flag moves only at edges. Biased random streams with occasional resets then drive a one-hot and a binary instance side by side. Both are compared with a pattern-window model for the flag and a transition-table model for the state.

// File: rtl/sqd_pkg.sv
package sqd_pkg;
   localparam int unsigned NUM_ST = 8;
   localparam int unsigned IDX_W  = $clog2(NUM_ST);

   localparam int ENC_ONEHOT = 0;
   localparam int ENC_BINARY = 1;

   typedef enum logic [IDX_W-1:0] {
      ST_A = 3'd0,
      ST_B = 3'd1,
      ST_C = 3'd2,
      ST_D = 3'd3,
      ST_E = 3'd4,
      ST_F = 3'd5,
      ST_G = 3'd6,
      ST_H = 3'd7
   } sqd_state_e;

   function automatic int unsigned code_width(input int enc);
      return (enc == ENC_ONEHOT) ? NUM_ST : IDX_W;
   endfunction
endpackage

// File: rtl/sqd_next_onehot.sv
module sqd_next_onehot
   import sqd_pkg::*;
(
   input  logic [NUM_ST-1:0] cur,
   input  logic              w,
   output logic [NUM_ST-1:0] nxt
);
   // Each state bit is set by the OR of its predecessors gated by the input.
   assign nxt[ST_A] =  w & (cur[ST_A] | cur[ST_G]);
   assign nxt[ST_B] = ~w & (cur[ST_A] | cur[ST_F]);
   assign nxt[ST_C] = ~w & (cur[ST_B] | cur[ST_H]);
   assign nxt[ST_D] = ~w &  cur[ST_C];
   assign nxt[ST_E] = ~w & (cur[ST_D] | cur[ST_E]);
   assign nxt[ST_F] =  w & (cur[ST_B] | cur[ST_C] | cur[ST_D] | cur[ST_E] | cur[ST_H]);
   assign nxt[ST_G] =  w &  cur[ST_F];
   assign nxt[ST_H] = ~w &  cur[ST_G];
endmodule

// File: rtl/sqd_next_binary.sv
module sqd_next_binary
   import sqd_pkg::*;
(
   input  logic [IDX_W-1:0] cur,
   input  logic             w,
   output logic [IDX_W-1:0] nxt
);
   sqd_state_e n;

   always_comb begin
      unique case (sqd_state_e'(cur))
         ST_A:    n = w ? ST_A : ST_B;
         ST_B:    n = w ? ST_F : ST_C;
         ST_C:    n = w ? ST_F : ST_D;
         ST_D:    n = w ? ST_F : ST_E;
         ST_E:    n = w ? ST_F : ST_E;
         ST_F:    n = w ? ST_G : ST_B;
         ST_G:    n = w ? ST_A : ST_H;
         ST_H:    n = w ? ST_F : ST_C;
         default: n = ST_A;
      endcase
   end

   assign nxt = n;
endmodule

// File: rtl/sqd_state_reg.sv
module sqd_state_reg #(
   parameter int unsigned W = 8,
   parameter logic [W-1:0] RST_CODE = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("sqd_state_reg: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= RST_CODE;
      else        q <= d;
   end
endmodule

// File: rtl/sqd_out_decode.sv
module sqd_out_decode
   import sqd_pkg::*;
#(
   parameter int          ENC_SEL = ENC_ONEHOT,
   parameter int unsigned CODE_W  = NUM_ST,
   parameter int unsigned OBS_W   = 8
) (
   input  logic [CODE_W-1:0] cur,
   output logic              z,
   output logic [OBS_W-1:0]  obs
);
   if (ENC_SEL == ENC_ONEHOT) begin : g_oh
      assign z = cur[ST_E] | cur[ST_H];
   end else begin : g_bin
      assign z = (cur == CODE_W'(ST_E)) | (cur == CODE_W'(ST_H));
   end

   always_comb begin
      obs = '0;
      obs[CODE_W-1:0] = cur;
   end
endmodule

// File: rtl/seq_dual_detect.sv
module seq_dual_detect
   import sqd_pkg::*;
#(
   parameter int          ENC_SEL = ENC_ONEHOT,
   parameter int unsigned OBS_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             w_in,
   output logic             z_out,
   output logic [OBS_W-1:0] st_obs
);
   localparam int unsigned    CODE_W   = code_width(ENC_SEL);
   localparam logic [CODE_W-1:0] RST_CODE =
      (ENC_SEL == ENC_ONEHOT) ? CODE_W'(1) : CODE_W'(0);

   if (ENC_SEL != ENC_ONEHOT && ENC_SEL != ENC_BINARY) begin : g_bad_enc
      $error("seq_dual_detect: ENC_SEL must be 0 (one-hot) or 1 (binary)");
   end
   if (OBS_W < CODE_W) begin : g_bad_obs
      $error("seq_dual_detect: OBS_W is narrower than the state code");
   end

   logic [CODE_W-1:0] cur_code;
   logic [CODE_W-1:0] nxt_code;

   sqd_state_reg #(
      .W        (CODE_W),
      .RST_CODE (RST_CODE)
   ) u_state (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (nxt_code),
      .q     (cur_code)
   );

   if (ENC_SEL == ENC_ONEHOT) begin : g_next_oh
      sqd_next_onehot u_next (
         .cur (cur_code),
         .w   (w_in),
         .nxt (nxt_code)
      );
   end else begin : g_next_bin
      sqd_next_binary u_next (
         .cur (cur_code),
         .w   (w_in),
         .nxt (nxt_code)
      );
   end

   sqd_out_decode #(
      .ENC_SEL (ENC_SEL),
      .CODE_W  (CODE_W),
      .OBS_W   (OBS_W)
   ) u_dec (
      .cur (cur_code),
      .z   (z_out),
      .obs (st_obs)
   );
endmodule

// File: rtl/sqd_checker.sv
module sqd_checker
   import sqd_pkg::*;
#(
   parameter int          ENC_SEL = ENC_ONEHOT,
   parameter int unsigned OBS_W   = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             w_in,
   input logic             z_out,
   input logic [OBS_W-1:0] st_obs
);
   localparam logic [OBS_W-1:0] A_OBS =
      (ENC_SEL == ENC_ONEHOT) ? OBS_W'(1) : OBS_W'(0);

   // Independent window of the last four samples since reset.
   logic [3:0] win;
   logic [2:0] seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win  <= '0;
         seen <= '0;
      end else begin
         win  <= {win[2:0], w_in};
         seen <= (seen == 3'd4) ? 3'd4 : seen + 3'd1;
      end
   end

   logic full_win;
   logic hit_zero;
   logic hit_pat;
   assign full_win = (seen == 3'd4);
   assign hit_zero = full_win && (win == 4'b0000);
   assign hit_pat  = full_win && (win == 4'b0110);

   p_zero_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
      hit_zero |-> z_out);

   p_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_zero && !w_in) |=> z_out);

   p_pattern_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_pat |-> z_out);

   p_no_false_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_zero || hit_pat) |-> !z_out);

   p_reset_a_r6: assert property (@(posedge clk)
      !rst_n |=> (st_obs == A_OBS && !z_out));

   p_moore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(st_obs) |-> $stable(z_out));

   if (ENC_SEL == ENC_ONEHOT) begin : g_chk_oh
      p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(st_obs) == 1);
   end else begin : g_chk_bin
      p_bin_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
         st_obs[OBS_W-1:IDX_W] == '0);
   end
endmodule

bind seq_dual_detect sqd_checker #(
   .ENC_SEL (ENC_SEL),
   .OBS_W   (OBS_W)
) u_sqd_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .w_in   (w_in),
   .z_out  (z_out),
   .st_obs (st_obs)
);

// File: tb/seq_dual_detect_tb_top.sv
`timescale 1ns/1ps
module seq_dual_detect_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       w_in = 1'b0;
   logic       z_oh, z_bin;
   logic [7:0] obs_oh, obs_bin;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   // Bench model: transition table for the state, sample window for the flag.
   int         m_st = 0;
   logic [3:0] m_win = '0;
   int         m_seen = 0;

   always #2.5 clk = ~clk;

   seq_dual_detect #(.ENC_SEL(0), .OBS_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .w_in(w_in), .z_out(z_oh), .st_obs(obs_oh));

   seq_dual_detect #(.ENC_SEL(1), .OBS_W(8)) dut_b_i (
      .clk(clk), .rst_n(rst_n), .w_in(w_in), .z_out(z_bin), .st_obs(obs_bin));

   function automatic int tbl_next(input int s, input bit w);
      case (s)
         0: return w ? 0 : 1;
         1: return w ? 5 : 2;
         2: return w ? 5 : 3;
         3: return w ? 5 : 4;
         4: return w ? 5 : 4;
         5: return w ? 6 : 1;
         6: return w ? 0 : 7;
         default: return w ? 5 : 2;
      endcase
   endfunction

   function automatic bit exp_z();
      return (m_seen >= 4) && (m_win == 4'b0000 || m_win == 4'b0110);
   endfunction

   function automatic string z_tag();
      if (m_seen >= 4 && m_win == 4'b0000) return "R1/R2";
      if (m_seen >= 4 && m_win == 4'b0110) return "R3/R2";
      return "R9";
   endfunction

   task automatic check_eq(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic verify_all();
      check_eq({z_tag(), " z one-hot"}, {7'd0, z_oh}, {7'd0, exp_z()});
      check_eq({z_tag(), " z binary"}, {7'd0, z_bin}, {7'd0, exp_z()});
      check_eq("R4/R8 one-hot state", obs_oh, 8'(1) << m_st);
      check_eq("R5/R8 binary state", obs_bin, 8'(m_st));
   endtask

   // Drive w, take one edge, update model, check at the falling edge.
   task automatic step(input bit w);
      w_in = w;
      @(posedge clk);
      if (!rst_n) begin
         m_st = 0; m_win = '0; m_seen = 0;
      end else begin
         m_st   = tbl_next(m_st, w);
         m_win  = {m_win[2:0], w};
         m_seen = (m_seen < 4) ? m_seen + 1 : 4;
      end
      @(negedge clk);
      verify_all();
   endtask

   task automatic seq(input logic [15:0] bits, input int len);
      for (int i = len - 1; i >= 0; i--) step(bits[i]);
   endtask

   // Between edges, toggle w and confirm the flag does not move (R7).
   task automatic moore_probe();
      logic zo, zb;
      zo = z_oh; zb = z_bin;
      w_in = ~w_in;
      #1;
      check_eq("R7 z one-hot held mid-cycle", {7'd0, z_oh}, {7'd0, zo});
      check_eq("R7 z binary held mid-cycle", {7'd0, z_bin}, {7'd0, zb});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      // R6: reset state
      rst_n = 1'b0;
      step(1'b0); step(1'b1); step(1'b0);
      check_eq("R6 reset one-hot state A", obs_oh, 8'h01);
      check_eq("R6 reset binary state A", obs_bin, 8'h00);
      rst_n = 1'b1;

      // R9: three zeros after reset give no hit; the fourth does (R1), the fifth keeps it (R2)
      seq(16'b0000, 3);
      check_eq("R9 no hit before fourth sample", {7'd0, z_oh}, 8'd0);
      step(1'b0);
      check_eq("R1 four zeros", {7'd0, z_oh}, 8'd1);
      moore_probe();
      step(1'b0);
      check_eq("R2 fifth zero keeps hit", {7'd0, z_bin}, 8'd1);
      step(1'b1);
      check_eq("R9 one after zero run clears", {7'd0, z_oh}, 8'd0);

      // R3 and R2: 0110110 gives two pattern hits
      seq(16'b0110, 4);
      check_eq("R3 pattern 0110", {7'd0, z_oh}, 8'd1);
      moore_probe();
      seq(16'b110, 3);
      check_eq("R2 overlapped second 0110", {7'd0, z_bin}, 8'd1);
      step(1'b0);
      check_eq("R8 H then 0 gives C, no hit", obs_bin, 8'd2);

      // Near misses
      seq(16'b0111, 4);
      check_eq("R9 0111 no hit", {7'd0, z_oh}, 8'd0);
      seq(16'b010, 3);
      check_eq("R9 010 no hit", {7'd0, z_oh}, 8'd0);

      // R6: reset is synchronous; lowering it mid-cycle changes nothing yet
      seq(16'b0000, 4);
      rst_n = 1'b0;
      #1;
      check_eq("R6 z held before reset edge", {7'd0, z_oh}, 8'd1);
      check_eq("R6 state held before reset edge", obs_oh, 8'h10);
      step(1'b0);
      check_eq("R6 reset edge returns to A", obs_oh, 8'h01);
      rst_n = 1'b1;
      // Pattern split by reset must not hit
      seq(16'b01, 2);
      rst_n = 1'b0; step(1'b1); rst_n = 1'b1;
      step(1'b0);
      check_eq("R9 pattern split by reset", {7'd0, z_oh}, 8'd0);

      // Biased random run with occasional resets
      for (int k = 0; k < 4000; k++) begin
         rst_n = ($urandom % 150) != 0;
         step(($urandom % 3) == 0);
         if ((k % 97) == 0) moore_probe();
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule